// File: doc/BRIEF.md
# Iterative 64-bit Integer Divider

This unit performs integer division for a 64-bit processor pipeline, one request at a time. A request carries a dividend, a divisor, a destination register tag and mode controls. The mode controls select signed or unsigned arithmetic, full-width or half-width (word) operands, and one of three operation kinds: plain quotient, extended-dividend quotient, or remainder. A single restoring shift-subtract engine produces both quotient and remainder magnitudes. A fix-up stage then applies signs, detects results that do not fit, and widens word results to the full register width.

The unit accepts a request only while it is idle and signals this on `req_ready`. It then returns exactly one result beat a fixed number of cycles later. The beat carries a valid strobe, a matching write enable, the echoed tag and the result data. Any case that cannot produce a representable result returns zero. This covers a zero divisor, a signed overflow and an extended quotient that does not fit.

Top module: `iter_divider`

## Requirements
- R1: `rsp_valid` is high for exactly one cycle per accepted request and stays low while a division is in progress. `req_ready` is low from acceptance until the result cycle. A request presented while `req_ready` is low is ignored: it produces no result and does not disturb the division in flight.
- R2: The result beat appears exactly XLEN+1 clock cycles after the accepting clock edge. At the default width this is 65 cycles, within a bound of 67.
- R3: `rsp_dest` equals the `req_dest` captured at acceptance, and `rsp_wr_en` is high exactly when `rsp_valid` is high.
- R4: Plain quotient on full-width operands truncates toward zero, in both signed and unsigned modes. For example, unsigned 0x10001000 / 0x1111 = 0xF001.
- R5: A zero divisor gives a result of zero in every mode. In word modes this means that the low half of the divisor is zero, whatever its upper half holds.
- R6: A signed quotient that does not fit its width gives zero. Full-width minimum / -1 gives 0, and word minimum (low half 0x80000000) / -1 gives 0.
- R7: Word quotient mode uses only the low halves of both operands. The quotient is sign-extended from the half width when signed and zero-extended when unsigned.
- R8: Full-width extended mode divides (dividend << XLEN) by the divisor. The result is zero when the signed quotient does not fit in XLEN bits, or, in unsigned mode, when the divisor is not greater than the dividend.
- R9: Word extended mode takes the operand from the upper half of the dividend, ignores its low half, and divides (operand << XLEN/2) by the low half of the divisor. An out-of-range quotient gives zero; unsigned needs divisor low half > dividend upper half. The result is sign- or zero-extended as in R7.
- R10: Remainder mode returns the truncating-division remainder, whose sign follows the dividend. In word mode the remainder is taken on the low halves and then sign-extended (signed) or zero-extended (unsigned).
- R11: Synchronous active-low reset returns the unit to idle: `rsp_valid` and `rsp_wr_en` are low and `req_ready` is high.
- R12: `req_kind` encoding: 0 selects plain quotient, 1 selects extended, 2 selects remainder, and 3 behaves exactly like 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; a request is taken on this cycle's edge |
| req_dividend | input | XLEN | Dividend operand |
| req_divisor | input | XLEN | Divisor operand |
| req_signed | input | 1 | 1 = signed arithmetic |
| req_word | input | 1 | 1 = half-width (word) operands |
| req_kind | input | 2 | 0 quotient, 1 extended, 2 remainder, 3 as 0 |
| req_dest | input | TAG_W | Destination register tag |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_wr_en | output | 1 | Register write enable, high with rsp_valid |
| rsp_dest | output | TAG_W | Echoed destination tag |
| rsp_data | output | XLEN | Result value |

## Verification
The hardest situations to reach are the narrow boundaries where a quotient just fails to fit. These are a signed magnitude of exactly half the range with each sign, and an unsigned extended divisor equal to, or one more than, the dividend. At full width, random operands almost never land on them. The stimulus therefore sweeps every operation kind against a grid of operands on an 8-bit instance, seeded with the minimum, maximum, -1 and half-width sign-boundary values. At that size every such boundary is hit many times. A 64-bit instance then covers directed overflow and zero-divisor cases in all modes, plus varied-length random operands.

// File: rtl/iter_divider_pkg.sv
// Package: shared types for the iterative divider.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package iter_divider_pkg;

    // Operation kind carried on req_kind.
    typedef enum logic [1:0] {
        DK_QUOT = 2'd0,
        DK_EXT  = 2'd1,
        DK_MOD  = 2'd2,
        DK_ALT  = 2'd3
    } div_kind_e;

    // Control states of the divider sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    // Per-request attributes held through the iteration.
    typedef struct packed {
        logic is_signed;
        logic is_word;
        logic is_mod;
        logic neg_quot;
        logic neg_rem;
        logic pre_ovf;
        logic den_zero;
    } div_flags_t;

endpackage

// File: rtl/div_operand_prep.sv
// Module: div_operand_prep
// Turns raw request operands into unsigned magnitudes and initial iteration
// state, and records the sign and special-case attributes.
// Assumes: XLEN is even; purely combinational, sampled at acceptance.
module div_operand_prep
    import iter_divider_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    input  logic            is_signed,
    input  logic            is_word,
    input  logic [1:0]      kind,
    output logic [XLEN-1:0] quo_init,
    output logic [XLEN-1:0] rem_init,
    output logic [XLEN-1:0] den_mag,
    output div_flags_t      flags
);
    localparam int HALF = XLEN / 2;

    logic            use_ext;
    logic            use_mod;
    logic            word_ext;
    logic            full_ext;
    logic [HALF-1:0] a_half;
    logic [XLEN-1:0] a_op;
    logic [XLEN-1:0] b_op;
    logic            a_neg;
    logic            b_neg;
    logic [XLEN-1:0] a_mag;
    logic [XLEN-1:0] b_mag;
    logic            early_ovf;

    // Select operands by width, take magnitudes, and set up the iteration.
    always_comb begin
        use_ext  = (kind == DK_EXT);
        use_mod  = (kind == DK_MOD);
        word_ext = is_word & use_ext;
        full_ext = ~is_word & use_ext;

        a_half = word_ext ? dividend[XLEN-1:HALF] : dividend[HALF-1:0];
        a_op   = is_word ? {{HALF{is_signed & a_half[HALF-1]}}, a_half} : dividend;
        b_op   = is_word ? {{HALF{is_signed & divisor[HALF-1]}}, divisor[HALF-1:0]}
                         : divisor;

        a_neg = is_signed & a_op[XLEN-1];
        b_neg = is_signed & b_op[XLEN-1];
        a_mag = a_neg ? (~a_op + 1'b1) : a_op;
        b_mag = b_neg ? (~b_op + 1'b1) : b_op;

        early_ovf = full_ext & (a_mag >= b_mag);

        if (word_ext) begin
            quo_init = a_mag << HALF;
        end else if (full_ext) begin
            quo_init = '0;
        end else begin
            quo_init = a_mag;
        end
        rem_init = (full_ext & ~early_ovf) ? a_mag : '0;
        den_mag  = b_mag;

        flags.is_signed = is_signed;
        flags.is_word   = is_word;
        flags.is_mod    = use_mod;
        flags.neg_quot  = a_neg ^ b_neg;
        flags.neg_rem   = a_neg;
        flags.pre_ovf   = early_ovf;
        flags.den_zero  = (b_mag == '0);
    end

endmodule

// File: rtl/div_iter_core.sv
// Module: div_iter_core
// Restoring shift-subtract engine: one quotient bit per step, XLEN steps.
// Assumes: rem_init < den when the quotient is to be used; load and step
// are never high together.
module div_iter_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] quo_init,
    input  logic [XLEN-1:0] rem_init,
    input  logic [XLEN-1:0] den_in,
    output logic [XLEN-1:0] quo_mag,
    output logic [XLEN-1:0] rem_mag,
    output logic            last
);
    localparam int CNT_W = $clog2(XLEN);

    logic [XLEN-1:0]  quo_q;
    logic [XLEN-1:0]  rem_q;
    logic [XLEN-1:0]  den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [XLEN:0]    partial;
    logic [XLEN:0]    diff;
    logic             fits;

    // Form the trial subtraction of the shifted remainder.
    always_comb begin
        partial = {rem_q, quo_q[XLEN-1]};
        diff    = partial - {1'b0, den_q};
        fits    = ~diff[XLEN];
    end

    // Load operands or advance one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            quo_q <= quo_init;
            rem_q <= rem_init;
            den_q <= den_in;
            cnt_q <= '0;
        end else if (step) begin
            quo_q <= {quo_q[XLEN-2:0], fits};
            rem_q <= fits ? diff[XLEN-1:0] : partial[XLEN-1:0];
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quo_mag = quo_q;
    assign rem_mag = rem_q;
    assign last    = step && (cnt_q == CNT_W'(XLEN - 1));

endmodule

// File: rtl/div_result_fix.sv
// Module: div_result_fix
// Applies signs, checks the quotient range, widens word results and forces
// zero for unrepresentable cases. Purely combinational.
// Assumes: magnitudes come from a completed XLEN-step iteration.
module div_result_fix
    import iter_divider_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] quo_mag,
    input  logic [XLEN-1:0] rem_mag,
    input  div_flags_t      flags,
    output logic [XLEN-1:0] result
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] LIM_FULL_S = XLEN'(1) << (XLEN - 1);
    localparam logic [XLEN-1:0] LIM_WORD_S = XLEN'(1) << (HALF - 1);
    localparam logic [XLEN-1:0] LIM_WORD_U = XLEN'(1) << HALF;

    logic [XLEN-1:0] lim_s;
    logic            ovf;
    logic [XLEN-1:0] quo_val;
    logic [XLEN-1:0] rem_val;
    logic [XLEN-1:0] quo_out;
    logic [XLEN-1:0] rem_out;

    // Range-check the quotient and build the final value.
    always_comb begin
        lim_s = flags.is_word ? LIM_WORD_S : LIM_FULL_S;
        if (flags.is_signed) begin
            ovf = flags.neg_quot ? (quo_mag > lim_s) : (quo_mag >= lim_s);
        end else begin
            ovf = flags.is_word & (quo_mag >= LIM_WORD_U);
        end

        quo_val = flags.neg_quot ? (~quo_mag + 1'b1) : quo_mag;
        rem_val = flags.neg_rem  ? (~rem_mag + 1'b1) : rem_mag;

        if (flags.is_word) begin
            quo_out = {{HALF{flags.is_signed & quo_val[HALF-1]}}, quo_val[HALF-1:0]};
            rem_out = {{HALF{flags.is_signed & rem_val[HALF-1]}}, rem_val[HALF-1:0]};
        end else begin
            quo_out = quo_val;
            rem_out = rem_val;
        end

        if (flags.den_zero) begin
            result = '0;
        end else if (flags.is_mod) begin
            result = rem_out;
        end else if (flags.pre_ovf || ovf) begin
            result = '0;
        end else begin
            result = quo_out;
        end
    end

endmodule

// File: rtl/iter_divider.sv
// Module: iter_divider (top)
// Single-request iterative divider: accepts when idle, iterates XLEN steps,
// spends one cycle on fix-up and emits a one-cycle result beat.
// Assumes: XLEN even and at least 4; synchronous active-low reset.
module iter_divider
    import iter_divider_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [XLEN-1:0]  req_dividend,
    input  logic [XLEN-1:0]  req_divisor,
    input  logic             req_signed,
    input  logic             req_word,
    input  logic [1:0]       req_kind,
    input  logic [TAG_W-1:0] req_dest,
    output logic             rsp_valid,
    output logic             rsp_wr_en,
    output logic [TAG_W-1:0] rsp_dest,
    output logic [XLEN-1:0]  rsp_data
);
    div_state_e       state_q;
    div_flags_t       flags_d;
    div_flags_t       flags_q;
    logic [TAG_W-1:0] dest_q;
    logic [XLEN-1:0]  quo_init;
    logic [XLEN-1:0]  rem_init;
    logic [XLEN-1:0]  den_mag;
    logic [XLEN-1:0]  quo_mag;
    logic [XLEN-1:0]  rem_mag;
    logic [XLEN-1:0]  fixed;
    logic             accept;
    logic             last_step;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && (state_q == ST_IDLE);

    div_operand_prep #(.XLEN(XLEN)) u_prep (
        .dividend (req_dividend),
        .divisor  (req_divisor),
        .is_signed(req_signed),
        .is_word  (req_word),
        .kind     (req_kind),
        .quo_init (quo_init),
        .rem_init (rem_init),
        .den_mag  (den_mag),
        .flags    (flags_d)
    );

    div_iter_core #(.XLEN(XLEN)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state_q == ST_RUN),
        .quo_init(quo_init),
        .rem_init(rem_init),
        .den_in  (den_mag),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag),
        .last    (last_step)
    );

    div_result_fix #(.XLEN(XLEN)) u_fix (
        .quo_mag(quo_mag),
        .rem_mag(rem_mag),
        .flags  (flags_q),
        .result (fixed)
    );

    // Sequence idle, iterate and fix-up; hold request attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            dest_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    flags_q <= flags_d;
                    dest_q  <= req_dest;
                end
                ST_RUN:  if (last_step) state_q <= ST_FIX;
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the one-cycle result beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_wr_en <= 1'b0;
            rsp_dest  <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (state_q == ST_FIX);
            rsp_wr_en <= (state_q == ST_FIX);
            if (state_q == ST_FIX) begin
                rsp_dest <= dest_q;
                rsp_data <= fixed;
            end
        end
    end

endmodule

// File: rtl/iter_divider_chk.sv
// Module: iter_divider_chk
// Protocol checker for iter_divider, attached by bind below.
// Assumes: same parameters as the bound divider.
module iter_divider_chk #(
    parameter int XLEN  = 64,
    parameter int TAG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [XLEN-1:0]  req_divisor,
    input logic             req_word,
    input logic [TAG_W-1:0] req_dest,
    input logic             rsp_valid,
    input logic             rsp_wr_en,
    input logic [TAG_W-1:0] rsp_dest,
    input logic [XLEN-1:0]  rsp_data
);
    localparam int HALF  = XLEN / 2;
    localparam int LAT_W = $clog2(XLEN + 4) + 1;
    localparam logic [LAT_W-1:0] LAT_AT_RSP = LAT_W'(XLEN + 2);

    logic             acc;
    logic [LAT_W-1:0] lat_q;
    logic [TAG_W-1:0] tag_q;
    logic             zero_q;

    assign acc = req_valid && req_ready;

    // Track cycles since acceptance and capture request attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            tag_q  <= '0;
            zero_q <= 1'b0;
        end else if (acc) begin
            lat_q  <= LAT_W'(1);
            tag_q  <= req_dest;
            zero_q <= req_word ? (req_divisor[HALF-1:0] == '0) : (req_divisor == '0);
        end else if (rsp_valid) begin
            lat_q <= '0;
        end else if (lat_q != '0) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !rsp_valid); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (lat_q == LAT_AT_RSP)); // R2
    AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en == rsp_valid); // R3
    AST_TAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_dest == tag_q)); // R3
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && zero_q) |-> (rsp_data == '0)); // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid)); // R11

endmodule

bind iter_divider iter_divider_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_divisor(req_divisor),
    .req_word   (req_word),
    .req_dest   (req_dest),
    .rsp_valid  (rsp_valid),
    .rsp_wr_en  (rsp_wr_en),
    .rsp_dest   (rsp_dest),
    .rsp_data   (rsp_data)
);

// File: tb/iter_divider_bench.sv
module iter_divider_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_err = 0;

    always #5 clk = ~clk;

    // 64-bit instance
    logic        b_rv = 0, b_rdy, b_sg = 0, b_wd = 0, b_ov, b_we;
    logic [63:0] b_a = 0, b_b = 0, b_d;
    logic [1:0]  b_k = 0;
    logic [4:0]  b_t = 0, b_ot;
    // 8-bit instance
    logic        s_rv = 0, s_rdy, s_sg = 0, s_wd = 0, s_ov, s_we;
    logic [7:0]  s_a = 0, s_b = 0, s_d;
    logic [1:0]  s_k = 0;
    logic [4:0]  s_t = 0, s_ot;

    iter_divider u_iter_divider (
        .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_ready(b_rdy),
        .req_dividend(b_a), .req_divisor(b_b), .req_signed(b_sg), .req_word(b_wd),
        .req_kind(b_k), .req_dest(b_t), .rsp_valid(b_ov), .rsp_wr_en(b_we),
        .rsp_dest(b_ot), .rsp_data(b_d));

    iter_divider #(.XLEN(8), .TAG_W(5)) u_iter_divider_small (
        .clk(clk), .rst_n(rst_n), .req_valid(s_rv), .req_ready(s_rdy),
        .req_dividend(s_a), .req_divisor(s_b), .req_signed(s_sg), .req_word(s_wd),
        .req_kind(s_k), .req_dest(s_t), .rsp_valid(s_ov), .rsp_wr_en(s_we),
        .rsp_dest(s_ot), .rsp_data(s_d));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic signed [127:0] sxt(input logic [127:0] v, input int n);
        logic [127:0] m;
        m = (128'd1 << n) - 1;
        v = v & m;
        if (v[n-1]) return $signed(v | ~m);
        return $signed(v);
    endfunction

    // Arithmetic model built from the requirements.
    function automatic logic [63:0] ref_div(input int x, input logic [63:0] a, input logic [63:0] b,
                                            input bit sg, input bit wd, input logic [1:0] kd);
        int n;
        logic [127:0] mk, ao, bo, uq;
        logic signed [127:0] sq, lim;
        bit ovf;
        n  = wd ? x / 2 : x;
        mk = (128'd1 << n) - 1;
        ao = (wd && kd == 2'd1) ? ((128'(a) >> (x / 2)) & mk) : (128'(a) & mk);
        bo = 128'(b) & mk;
        if (bo == 0) return 64'd0;
        if (kd == 2'd2) begin
            if (sg) uq = sxt(ao, n) % sxt(bo, n);
            else    uq = ao % bo;
        end else begin
            if (sg) begin
                sq  = (kd == 2'd1) ? (sxt(ao, n) <<< n) : sxt(ao, n);
                sq  = sq / sxt(bo, n);
                lim = 128'sd1 <<< (n - 1);
                ovf = (sq >= lim) || (sq < -lim);
                uq  = sq;
            end else begin
                uq  = (kd == 2'd1) ? (ao << n) : ao;
                uq  = uq / bo;
                ovf = (uq >> n) != 0;
            end
            if (ovf) return 64'd0;
        end
        uq = sg ? sxt(uq, n) : (uq & mk);
        uq = uq & ((128'd1 << x) - 1);
        return uq[63:0];
    endfunction

    function automatic string mode_tag(input bit wd, input logic [1:0] kd);
        if (kd == 2'd2) return "R10";
        if (kd == 2'd1) return wd ? "R9" : "R8";
        if (kd == 2'd3) return "R12";
        return wd ? "R7" : "R4";
    endfunction

    // Issue one request and wait for its result; returns cycles from acceptance.
    task automatic do_op(input bit big, input logic [63:0] a, input logic [63:0] b, input bit sg,
                         input bit wd, input logic [1:0] kd, input logic [4:0] t,
                         output logic [63:0] d, output logic [4:0] ot, output bit we, output int lat);
        @(negedge clk);
        if (big) begin
            b_rv = 1; b_a = a; b_b = b; b_sg = sg; b_wd = wd; b_k = kd; b_t = t;
        end else begin
            s_rv = 1; s_a = a[7:0]; s_b = b[7:0]; s_sg = sg; s_wd = wd; s_k = kd; s_t = t;
        end
        @(negedge clk);
        b_rv = 0; s_rv = 0;
        lat = 0;
        while (lat < 300) begin
            @(negedge clk);
            lat++;
            if (big ? b_ov : s_ov) break;
        end
        d  = big ? b_d : {56'd0, s_d};
        ot = big ? b_ot : s_ot;
        we = big ? b_we : s_we;
    endtask

    task automatic run_chk(input bit big, input logic [63:0] a, input logic [63:0] b, input bit sg,
                           input bit wd, input logic [1:0] kd, input string tag);
        logic [63:0] d;
        logic [4:0]  ot;
        bit          we;
        int          lat;
        logic [4:0]  t;
        int          x;
        x = big ? 64 : 8;
        t = 5'(a[4:0] ^ b[9:5] ^ {3'd0, kd});
        do_op(big, a, b, sg, wd, kd, t, d, ot, we, lat);
        chk(tag, d, ref_div(x, a, b, sg, wd, kd));
        chk("R2 latency", 64'(lat), 64'(x + 1));
        chk("R3 tag", {58'd0, we, ot}, {58'd0, 1'b1, t});
    endtask

    function automatic logic [63:0] rnd64();
        logic [63:0] v;
        v = {$urandom(), $urandom()};
        v = v >> ($urandom() % 64);
        if ($urandom() % 2) v = -v;
        return v;
    endfunction

    function automatic logic [7:0] pick(input int i);
        case (i)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h7F;  3: return 8'h80;
            4: return 8'hFF;  5: return 8'h08;  6: return 8'hF8;  7: return 8'h07;
            default: return 8'(i * 37 + 11);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [4:0]  ot;
        bit          we;
        int          lat;

        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 valid in reset", {62'd0, b_ov, s_ov}, 64'd0);
        chk("R11 ready in reset", {62'd0, b_rdy, s_rdy}, 64'd3);
        rst_n = 1;
        @(negedge clk);
        chk("R11 idle after reset", {60'd0, b_ov, b_we, b_rdy, s_rdy}, 64'd3);

        // R4: directed unsigned quotient
        do_op(1, 64'h10001000, 64'h1111, 0, 0, 2'd0, 5'd17, d, ot, we, lat);
        chk("R4 0x10001000/0x1111", d, 64'hF001);
        chk("R3 tag echo", {58'd0, we, ot}, {58'd0, 1'b1, 5'd17});
        chk("R2 latency 65", 64'(lat), 64'd65);

        // R6: signed overflow cases
        do_op(1, 64'h8000000000000000, '1, 1, 0, 2'd0, 5'd1, d, ot, we, lat);
        chk("R6 full min/-1", d, 64'd0);
        do_op(1, 64'hFFFFFFFF80000000, '1, 1, 1, 2'd0, 5'd2, d, ot, we, lat);
        chk("R6 word min/-1", d, 64'd0);
        do_op(1, 64'h0000000080000000, 64'h00000000FFFFFFFF, 1, 1, 2'd0, 5'd3, d, ot, we, lat);
        chk("R6 word min/-1 upper ignored", d, 64'd0);

        // R8 / R9 / R10 directed boundaries
        do_op(1, 64'd5, 64'd5, 0, 0, 2'd1, 5'd4, d, ot, we, lat);
        chk("R8 unsigned ext divisor equal", d, 64'd0);
        run_chk(1, 64'd5, 64'd6, 0, 0, 2'd1, "R8 unsigned ext divisor larger");
        run_chk(1, 64'h0000000512345678, 64'hABCDEF0000000006, 0, 1, 2'd1, "R9 word ext unsigned");
        do_op(1, 64'h0000000600000000, 64'd6, 0, 1, 2'd1, 5'd5, d, ot, we, lat);
        chk("R9 word ext divisor not larger", d, 64'd0);
        do_op(1, -64'sd7, 64'd2, 1, 0, 2'd2, 5'd6, d, ot, we, lat);
        chk("R10 signed remainder -7%2", d, 64'hFFFFFFFFFFFFFFFF);
        do_op(1, 64'h12345678FFFFFFF9, 64'd2, 1, 1, 2'd2, 5'd7, d, ot, we, lat);
        chk("R10 word signed remainder", d, 64'hFFFFFFFFFFFFFFFF);

        // R5: zero divisor in every mode
        for (int m = 0; m < 12; m++) begin
            bit w;
            w = m[1];
            do_op(1, rnd64(), w ? 64'hFFFFFFFF00000000 : 64'd0, m[0], w, 2'(m / 4), 5'(m), d, ot, we, lat);
            chk("R5 zero divisor", d, 64'd0);
        end

        // R1: request while busy is ignored
        @(negedge clk);
        s_rv = 1; s_a = 8'd100; s_b = 8'd7; s_sg = 0; s_wd = 0; s_k = 2'd0; s_t = 5'd3;
        @(negedge clk);
        s_rv = 0;
        repeat (3) @(negedge clk);
        chk("R1 ready low while busy", {63'd0, s_rdy}, 64'd0);
        s_rv = 1; s_a = 8'd200; s_b = 8'd3; s_t = 5'd9;
        @(negedge clk);
        s_rv = 0;
        lat = 4;
        while (!s_ov && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk("R1 first result kept", {51'd0, s_ot, s_d}, {51'd0, 5'd3, 8'd14});
        chk("R1 no early valid", 64'(lat), 64'd9);
        @(negedge clk);
        chk("R1 valid one cycle", {63'd0, s_ov}, 64'd0);
        lat = 0;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            if (s_ov) lat++;
        end
        chk("R1 ignored request gave no result", 64'(lat), 64'd0);

        // 64-bit random operands across all modes
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < 30; i++) begin
                run_chk(1, rnd64(), rnd64(), m[0], m[1], 2'(m / 4), mode_tag(m[1], 2'(m / 4)));
            end
        end

        // 8-bit sweep over every mode
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < 24; i++) begin
                for (int j = 0; j < 24; j++) begin
                    run_chk(0, {56'd0, pick(i)}, {56'd0, pick(j)}, m[0], m[1], 2'(m / 4),
                            mode_tag(m[1], 2'(m / 4)));
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule